// File: doc/BRIEF.md
# Prescaled multi-channel PWM bank

This block is a bank of up to eight pulse-width modulated outputs behind a small 32-bit register bus. Software programs each channel through its own group of three words: a control word, a period and a duty threshold. It then starts or stops channels through one shared enable word. Each channel divides a base tick by a power of two and runs a counter from zero up to its period. The channel output is high while the counter is below the threshold.

The base tick comes from one of two sources, chosen by a source-select word. The first source is a strobe, `ref_tick`, produced by a slower reference time base. The second is every cycle of the bus clock. Each channel runs a two-state controller:
- CH_IDLE: the counter and prescaler are held at zero and the output is low.
- CH_RUN: the channel counts.

The controller has three transitions:
- START (CH_IDLE to CH_RUN): taken when the enable bit and the mode bit are both set.
- STOP (CH_RUN to CH_IDLE): taken when either bit clears.
- WRAP (CH_RUN to CH_RUN): taken at the period boundary. It reloads the active period, threshold and divider from the programmed registers.

Channels at index 3 and above can be built with a shifted register layout (`ALT_LAYOUT`).

Top module: `pwm_bank`

## Requirements
- R1: After reset the following hold: the enable word reads 0, every channel register reads 0, the source-select word reads 1, and every output is low.
- R2: The enable word at offset 0x000 holds one bit per channel, with bit n for channel n. It reads back what was written, and bits at and above NUM_CH read 0.
- R3: Channel n's group starts at base 0x010, 0x050, 0x090, 0x0D0, 0x110, 0x150, 0x190 or 0x220 for n = 0 to 7. Within a group, the control word is at +0x00, the period at +0x2C and the threshold at +0x30.
- R4: Control bits [2:0] hold the divider select and bit 15 holds the compare-mode bit. All other bits read 0. A channel runs only while both its enable bit and its mode bit are 1.
- R5: The period keeps 13 bits (largest value 8191) and the threshold keeps 14 bits. Wider write data is truncated on readback.
- R6: A running channel counts 0, 1, ..., P and then wraps, so one output period is P+1 counter steps. The output is high exactly while count < T.
- R7: With T = 0 the output stays low. With T > P the output stays high.
- R8: With divider select D, the counter advances once per 2^D base ticks.
- R9: The source-select word at 0x210 (bit 0) chooses the base tick. A 1 (the reset value) uses the `ref_tick` strobe. A 0 uses every bus clock cycle.
- R10: Clearing a channel's enable bit drives its output low and holds its counter at 0 from the next cycle. Re-enabling restarts the channel at count 0.
- R11: New period, threshold and divider values take effect only at the next WRAP. The running period finishes with the old values.
- R12: With ALT_LAYOUT = 1, channels at index 3 and above place the period at +0x30 and the threshold at +0x34. In that layout +0x2C is unmapped.
- R13: Unmapped offsets read 0 and writes to them change nothing. This includes unaligned addresses and the groups of channels at or above NUM_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe from the reference time base |
| wr_en | input | 1 | Write strobe; data is stored on the rising edge |
| addr | input | 12 | Byte address of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pwm_out | output | NUM_CH | One modulated output per channel |

## Verification
The in-line properties check the following on every cycle:
- the counter never passes the active period;
- the prescaler never passes its limit;
- the counter holds between ticks;
- the active values stay frozen between wraps;
- a stopped channel is low at zero count;
- writes to the enable word, the source word and unmapped addresses have the expected effect.

Only the bench's scenarios show the following:
- the exact waveform shape for given period, threshold and divider values;
- the deferral of a mid-period threshold or divider change to the next WRAP;
- the phase restart after re-enabling;
- the switch of tick source;
- the shifted register layout.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int MAX_CH   = 8;
    localparam int MODE_BIT = 15;

    localparam logic [ADDR_W-1:0] ADDR_EN     = 12'h000;
    localparam logic [ADDR_W-1:0] ADDR_SRC    = 12'h210;
    localparam logic [ADDR_W-1:0] OFF_CTL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_PER_STD = 12'h02C;
    localparam logic [ADDR_W-1:0] OFF_THR_STD = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_PER_ALT = 12'h030;
    localparam logic [ADDR_W-1:0] OFF_THR_ALT = 12'h034;

    typedef enum logic {CH_IDLE, CH_RUN} ch_state_e;

    // Start of each channel's register group (irregular spacing, R3)
    function automatic logic [ADDR_W-1:0] win_base(input int ch);
        logic [ADDR_W-1:0] b;
        unique case (ch)
            0:       b = 12'h010;
            1:       b = 12'h050;
            2:       b = 12'h090;
            3:       b = 12'h0D0;
            4:       b = 12'h110;
            5:       b = 12'h150;
            6:       b = 12'h190;
            7:       b = 12'h220;
            default: b = 12'hFF0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int PER_W      = 13,
    parameter int THR_W      = 14,
    parameter int DIV_W      = 3,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter int ALT_FIRST  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    output logic [NUM_CH-1:0]                 en_o,
    output logic [NUM_CH-1:0]                 mode_o,
    output logic [NUM_CH-1:0][DIV_W-1:0]      div_o,
    output logic [NUM_CH-1:0][PER_W-1:0]      per_o,
    output logic [NUM_CH-1:0][THR_W-1:0]      thr_o,
    output logic                              src_ref_o
);

    logic [NUM_CH-1:0]             en_q;
    logic                          src_q;
    logic [NUM_CH-1:0]             hit_ch;
    logic [NUM_CH-1:0][DATA_W-1:0] rd_ch;
    logic                          hit_any;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam bit USE_ALT = ALT_LAYOUT && (g >= ALT_FIRST);
        localparam logic [ADDR_W-1:0] A_CTL = win_base(g) + OFF_CTL;
        localparam logic [ADDR_W-1:0] A_PER = win_base(g) + (USE_ALT ? OFF_PER_ALT : OFF_PER_STD);
        localparam logic [ADDR_W-1:0] A_THR = win_base(g) + (USE_ALT ? OFF_THR_ALT : OFF_THR_STD);

        logic              sel_ctl, sel_per, sel_thr;
        logic              mode_q;
        logic [DIV_W-1:0]  div_q;
        logic [PER_W-1:0]  per_q;
        logic [THR_W-1:0]  thr_q;
        logic [DATA_W-1:0] rd_w;

        assign sel_ctl   = (addr == A_CTL);
        assign sel_per   = (addr == A_PER);
        assign sel_thr   = (addr == A_THR);
        assign hit_ch[g] = sel_ctl | sel_per | sel_thr;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mode_q <= 1'b0;
                div_q  <= '0;
                per_q  <= '0;
                thr_q  <= '0;
            end else if (wr_en) begin
                if (sel_ctl) begin
                    mode_q <= wdata[MODE_BIT];
                    div_q  <= wdata[DIV_W-1:0];
                end
                if (sel_per) per_q <= wdata[PER_W-1:0];
                if (sel_thr) thr_q <= wdata[THR_W-1:0];
            end
        end

        always_comb begin
            rd_w = '0;
            if (sel_ctl) begin
                rd_w[MODE_BIT]    = mode_q;
                rd_w[DIV_W-1:0]   = div_q;
            end else if (sel_per) begin
                rd_w[PER_W-1:0]   = per_q;
            end else if (sel_thr) begin
                rd_w[THR_W-1:0]   = thr_q;
            end
        end

        assign rd_ch[g]  = rd_w;
        assign mode_o[g] = mode_q;
        assign div_o[g]  = div_q;
        assign per_o[g]  = per_q;
        assign thr_o[g]  = thr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            src_q <= 1'b1;
        end else if (wr_en) begin
            if (addr == ADDR_EN)  en_q  <= wdata[NUM_CH-1:0];
            if (addr == ADDR_SRC) src_q <= wdata[0];
        end
    end

    assign hit_any = (addr == ADDR_EN) | (addr == ADDR_SRC) | (|hit_ch);

    always_comb begin
        rdata = '0;
        if (addr == ADDR_EN)  rdata[NUM_CH-1:0] = en_q;
        if (addr == ADDR_SRC) rdata[0]          = src_q;
        for (int c = 0; c < NUM_CH; c++) rdata = rdata | rd_ch[c];
    end

    assign en_o      = en_q;
    assign src_ref_o = src_q;

    // R2: a write to the enable word lands exactly
    p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_EN) |=> (en_q == $past(wdata[NUM_CH-1:0])));

    // R9: source select follows its written bit
    p_src_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_SRC) |=> (src_q == $past(wdata[0])));

    // R13: a write that hits nothing leaves all state untouched
    p_unmapped_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_any) |=> ($stable(en_q) && $stable(src_q) && $stable(mode_o)
                                 && $stable(div_o) && $stable(per_o) && $stable(thr_o)));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int PER_W = 13,
    parameter int THR_W = 14,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_tick,
    input  logic             run_req,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PER_W-1:0] per_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             pwm_o
);

    localparam int PRE_W = (1 << DIV_W) - 1;

    ch_state_e        state_q, state_d;
    logic [PRE_W-1:0] pre_q, pre_lim;
    logic [PER_W-1:0] cnt_q, act_per_q;
    logic [THR_W-1:0] act_thr_q;
    logic [DIV_W-1:0] act_div_q;
    logic             tick, wrap;

    assign pre_lim = {PRE_W{1'b1}} >> (PRE_W - int'(act_div_q));
    assign tick    = (state_q == CH_RUN) && base_tick && (pre_q == pre_lim);
    assign wrap    = tick && (cnt_q >= act_per_q);

    // Transitions START, STOP and WRAP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (run_req)  state_d = CH_RUN;
            CH_RUN:  if (!run_req) state_d = CH_IDLE;
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pre_q     <= '0;
            act_per_q <= '0;
            act_thr_q <= '0;
            act_div_q <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    cnt_q <= '0;
                    pre_q <= '0;
                    if (run_req) begin
                        act_per_q <= per_i;
                        act_thr_q <= thr_i;
                        act_div_q <= div_i;
                    end
                end
                CH_RUN: begin
                    if (!run_req) begin
                        cnt_q <= '0;
                        pre_q <= '0;
                    end else if (wrap) begin
                        cnt_q     <= '0;
                        pre_q     <= '0;
                        act_per_q <= per_i;
                        act_thr_q <= thr_i;
                        act_div_q <= div_i;
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                        pre_q <= '0;
                    end else if (base_tick) begin
                        pre_q <= pre_q + 1'b1;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    pre_q <= '0;
                end
            endcase
        end
    end

    always_comb begin
        pwm_o = (state_q == CH_RUN) && (THR_W'(cnt_q) < act_thr_q);
    end

    // R6: the count never passes the active period
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |-> (cnt_q <= act_per_q));

    // R8: prescaler stays within its 2^D window
    p_pre_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |-> (pre_q <= pre_lim));

    // R8: the counter moves only on a prescaled tick
    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && run_req && !tick) |=> $stable(cnt_q));

    // R11: active values are frozen between wraps
    p_shadow_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && run_req && !wrap) |=>
            ($stable(act_per_q) && $stable(act_thr_q) && $stable(act_div_q)));

    // R10: a stopped channel is low with a zero count next cycle
    p_stop_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_req |=> (cnt_q == '0 && !pwm_o));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int PER_W      = 13,
    parameter int DIV_W      = 3,
    parameter bit ALT_LAYOUT = 1'b0,
    parameter int ALT_FIRST  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int THR_W = PER_W + 1;

    logic [NUM_CH-1:0]            en, mode;
    logic [NUM_CH-1:0][DIV_W-1:0] div;
    logic [NUM_CH-1:0][PER_W-1:0] per;
    logic [NUM_CH-1:0][THR_W-1:0] thr;
    logic                         src_ref;
    logic                         base_tick;

    pwm_regs #(
        .NUM_CH     (NUM_CH),
        .PER_W      (PER_W),
        .THR_W      (THR_W),
        .DIV_W      (DIV_W),
        .ALT_LAYOUT (ALT_LAYOUT),
        .ALT_FIRST  (ALT_FIRST)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .en_o      (en),
        .mode_o    (mode),
        .div_o     (div),
        .per_o     (per),
        .thr_o     (thr),
        .src_ref_o (src_ref)
    );

    assign base_tick = src_ref ? ref_tick : 1'b1;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_chan #(
            .PER_W (PER_W),
            .THR_W (THR_W),
            .DIV_W (DIV_W)
        ) i_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .base_tick (base_tick),
            .run_req   (en[g] & mode[g]),
            .div_i     (div[g]),
            .per_i     (per[g]),
            .thr_i     (thr[g]),
            .pwm_o     (pwm_out[g])
        );
    end

endmodule

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        wr_en_a = 1'b0;
    logic        wr_en_b = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic [7:0]  pwm_a;
    logic [4:0]  pwm_b;

    logic [7:0]  q_mask[$];
    logic [7:0]  q_val[$];
    string       q_tag[$];
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_bank i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en_a),
        .addr(addr), .wdata(wdata), .rdata(rdata_a), .pwm_out(pwm_a)
    );

    pwm_bank #(.NUM_CH(5), .ALT_LAYOUT(1'b1)) i_pwm_bank_alt (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en_b),
        .addr(addr), .wdata(wdata), .rdata(rdata_b), .pwm_out(pwm_b)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input bit b, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr  = a;
        wdata = d;
        if (b) wr_en_b = 1'b1; else wr_en_a = 1'b1;
        @(negedge clk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
    endtask

    task automatic rd(input bit b, input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        @(negedge clk);
        addr = a;
        #1;
        v = b ? rdata_b : rdata_a;
        check(v == exp, tag, v, exp);
    endtask

    task automatic sample(input logic [7:0] m, input logic [7:0] v, input string tag);
        @(negedge clk);
        #1;
        check((pwm_a & m) == v, tag, pwm_a & m, v);
    endtask

    task automatic push(input logic [7:0] m, input logic [7:0] v, input string tag);
        q_mask.push_back(m);
        q_val.push_back(v);
        q_tag.push_back(tag);
    endtask

    task automatic push_wave(input logic [7:0] m, input int hi, input int lo, input int reps, input string tag);
        for (int r = 0; r < reps; r++) begin
            for (int i = 0; i < hi; i++) push(m, m, tag);
            for (int i = 0; i < lo; i++) push(m, 8'h00, tag);
        end
    endtask

    task automatic drain();
        while (q_val.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Scoreboard monitor: one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q_val.size() > 0) begin
                logic [7:0] m, v;
                string      t;
                m = q_mask.pop_front();
                v = q_val.pop_front();
                t = q_tag.pop_front();
                check((pwm_a & m) == v, t, pwm_a & m, v);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(0, 12'h000, 32'h0, "R1 enable word");
        rd(0, 12'h210, 32'h1, "R1 source select");
        rd(0, 12'h010, 32'h0, "R1 ch0 control");
        rd(0, 12'h03C, 32'h0, "R1 ch0 period");
        sample(8'hFF, 8'h00, "R1 outputs low");

        // R4 R5: field masks on readback
        wr(0, 12'h010, 32'hFFFF_FFFF);
        rd(0, 12'h010, 32'h0000_8007, "R4 control fields");
        wr(0, 12'h03C, 32'hFFFF_FFFF);
        rd(0, 12'h03C, 32'h0000_1FFF, "R5 period 13 bits");
        wr(0, 12'h040, 32'hFFFF_FFFF);
        rd(0, 12'h040, 32'h0000_3FFF, "R5 threshold 14 bits");
        // R3: irregular group bases
        wr(0, 12'h24C, 32'h123);
        rd(0, 12'h24C, 32'h123, "R3 ch7 period");
        wr(0, 12'h140, 32'h55);
        rd(0, 12'h140, 32'h55, "R3 ch4 threshold");

        // R2 R4: enable bits, no run without mode bit
        wr(0, 12'h010, 32'h0);
        wr(0, 12'h000, 32'hFFFF_FF5A);
        rd(0, 12'h000, 32'h5A, "R2 enable readback");
        sample(8'hFF, 8'h00, "R4 mode bit clear keeps low");
        sample(8'hFF, 8'h00, "R4 mode bit clear keeps low");
        wr(0, 12'h000, 32'h0);

        // R13: unmapped accesses
        wr(0, 12'h004, 32'hFFFF_FFFF);
        rd(0, 12'h004, 32'h0, "R13 unmapped read");
        rd(0, 12'h000, 32'h0, "R13 enable untouched");
        wr(0, 12'h012, 32'hFFFF_FFFF);
        rd(0, 12'h010, 32'h0, "R13 unaligned write ignored");
        rd(0, 12'h02C, 32'h0, "R13 gap in group");

        // R9: reference strobe source, then bus clock
        wr(0, 12'h0D0, 32'h8000);
        wr(0, 12'h0FC, 32'd1);
        wr(0, 12'h100, 32'd1);
        wr(0, 12'h000, 32'h08);
        for (int i = 0; i < 6; i++) sample(8'h08, 8'h08, "R9 no ref strobe holds count");
        wr(0, 12'h210, 32'h0);
        push(8'h08, 8'h08, "R9 bus clock ticks");
        push_wave(8'h08, 0, 1, 1, "R9 bus clock ticks");
        push_wave(8'h08, 1, 1, 2, "R9 bus clock ticks");
        drain();
        rd(0, 12'h210, 32'h0, "R9 source readback");
        wr(0, 12'h000, 32'h0);
        for (int i = 0; i < 3; i++) sample(8'h08, 8'h00, "R10 stop drives low");

        // R6 R11: basic waveform, threshold change deferred to wrap
        wr(0, 12'h010, 32'h8000);
        wr(0, 12'h03C, 32'd4);
        wr(0, 12'h040, 32'd2);
        wr(0, 12'h000, 32'h01);
        push(8'h01, 8'h00, "R6 idle before start");
        push_wave(8'h01, 2, 3, 1, "R11 old threshold finishes");
        push_wave(8'h01, 4, 1, 3, "R6 new threshold after wrap");
        wr(0, 12'h040, 32'd4);
        drain();

        // R10: stop then restart at count zero
        wr(0, 12'h000, 32'h0);
        for (int i = 0; i < 4; i++) sample(8'h01, 8'h00, "R10 stopped low");
        wr(0, 12'h000, 32'h01);
        push(8'h01, 8'h00, "R10 restart");
        push_wave(8'h01, 4, 1, 2, "R10 restart from zero");
        drain();
        wr(0, 12'h000, 32'h0);

        // R7: threshold above period and threshold zero
        wr(0, 12'h050, 32'h8000);
        wr(0, 12'h07C, 32'd3);
        wr(0, 12'h080, 32'd9);
        wr(0, 12'h090, 32'h8000);
        wr(0, 12'h0BC, 32'd3);
        wr(0, 12'h0C0, 32'd0);
        wr(0, 12'h000, 32'h06);
        push(8'h06, 8'h00, "R7 idle before start");
        for (int i = 0; i < 8; i++) push(8'h06, 8'h02, "R7 constant high and low");
        drain();
        wr(0, 12'h000, 32'h0);

        // R8 R11: divide by 2, then divider change deferred
        wr(0, 12'h150, 32'h8001);
        wr(0, 12'h17C, 32'd2);
        wr(0, 12'h180, 32'd1);
        wr(0, 12'h000, 32'h20);
        push(8'h20, 8'h00, "R8 idle before start");
        push_wave(8'h20, 2, 4, 1, "R8 divide by two");
        push_wave(8'h20, 1, 2, 2, "R11 divider after wrap");
        wr(0, 12'h150, 32'h8000);
        drain();
        wr(0, 12'h000, 32'h0);

        // R12 R13: shifted layout instance with five channels
        wr(1, 12'h100, 32'd7);
        rd(1, 12'h100, 32'd7, "R12 ch3 period shifted");
        wr(1, 12'h104, 32'd5);
        rd(1, 12'h104, 32'd5, "R12 ch3 threshold shifted");
        rd(1, 12'h0FC, 32'h0, "R12 old period slot unmapped");
        wr(1, 12'h07C, 32'd6);
        rd(1, 12'h07C, 32'd6, "R12 ch1 keeps standard layout");
        wr(1, 12'h080, 32'd3);
        rd(1, 12'h080, 32'd3, "R12 ch1 threshold standard");
        wr(1, 12'h190, 32'h8001);
        rd(1, 12'h190, 32'h0, "R13 absent channel group");
        wr(1, 12'h000, 32'hFF);
        rd(1, 12'h000, 32'h1F, "R2 enable bits limited to NUM_CH");
        wr(1, 12'h000, 32'h0);

        drain();
        finish_run();
    end

endmodule